// File: doc/BRIEF.md
# MDIO Management Command Bridge

This block lets a processor run Clause 22 PHY management transactions through two 32-bit registers. Software writes a command word that holds the PHY address, the PHY register number, an operation select and, for writes, the 16-bit data. The bridge then produces one complete serial management frame on a clock line (MDC) and a data line (MDIO). The data line is split into an output, an output enable and an input, so a pad cell can build the bidirectional pin.

A second register reports progress. It has a sticky completion flag for writes and a separate one for reads, and the 16 bits captured from the PHY sit in its upper half. Software polls the flag for its operation. Starting an operation clears that flag, and the end of the frame sets it again. A command that arrives while a frame is running is dropped.

MDC is derived from the system clock by a divider that is fixed at build time. MDIO changes only after a falling edge of MDC and is sampled on a rising edge.

Top module: `mdio_cmd_bridge`

## Requirements
- R1: After reset, MDC is low and MDIO is released (output enable low). The status register reads 0xFFFF0000: read data 0xFFFF and both completion flags 0.
- R2: The command fields are PHY address in bits 4:0, register number in bits 12:8, write request in bit 13, read request in bit 14, and write data in bits 31:16. If bits 13 and 14 are both set, a read is performed. A command with neither bit set starts nothing.
- R3: A write frame is 64 bits sent MSB first, in this order: 32 ones, 01, opcode 01, the 5-bit address, the 5-bit register number, 10, and then the 16 data bits. MDIO is driven for the whole frame.
- R4: A read frame uses opcode 10 and releases MDIO for its last 18 bits (turnaround and data). The 16 data bits are sampled MSB first into status bits 31:16.
- R5: MDC stays low for HALF_CYCLES clocks after a command is accepted, then toggles every HALF_CYCLES clocks. Each frame bit occupies one MDC period. MDIO changes only after a falling edge of MDC, and MDC is low while the bridge is idle.
- R6: An accepted write clears status bit 0. An accepted read clears status bit 1 and sets the read data to 0xFFFF. The matching flag, and for a read the captured data, is set 128*HALF_CYCLES clocks after acceptance. The other flag is left unchanged.
- R7: A command written while a frame is running is ignored, including one written in the cycle the frame ends. Writes to the status address are ignored.
- R8: Register address 0 reads back the last accepted command word. Address 1 reads the status word, whose bits 15:2 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 command, 1 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the selected address |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data output |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data input |

## Verification
The assertions assume that the register write strobe is a clean one-cycle-per-write signal that is synchronous to clk. They also assume that the PHY holds mdio_i steady around each rising edge of MDC. The stimulus drives every input only between clock edges. The PHY model in the bench changes mdio_i only at bit boundaries, and only when the frame index comes from the bench's own timing model, so each value is stable for a full MDC period before it is sampled. Commands are offered while a frame runs, in the exact cycle a frame ends, and to the status address, so that the ignore rules are exercised under the same assumptions.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;
  localparam int FRAME_BITS  = 64;
  localparam int IDX_W       = $clog2(FRAME_BITS);
  localparam int RD_RELEASE  = 46;
  localparam int RD_CAPTURE  = 48;

  typedef struct packed {
    logic        rd;
    logic [4:0]  phy;
    logic [4:0]  regn;
    logic [15:0] data;
  } mdio_cmd_t;

  function automatic mdio_cmd_t decode_cmd(input logic [31:0] w);
    mdio_cmd_t c;
    c.rd   = w[14];
    c.phy  = w[4:0];
    c.regn = w[12:8];
    c.data = w[31:16];
    return c;
  endfunction

  function automatic logic [FRAME_BITS-1:0] build_frame(input mdio_cmd_t c);
    return {32'hFFFF_FFFF, 2'b01, (c.rd ? 2'b10 : 2'b01), c.phy, c.regn,
            2'b10, (c.rd ? 16'h0000 : c.data)};
  endfunction
endpackage

// File: rtl/mdio_tick_gen.sv
module mdio_tick_gen #(
  parameter int HALF_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_en,
  output logic fall_en
);
  logic mdc_q, mdc_d;
  logic wrap;

  generate
    if (HALF_CYCLES == 1) begin : g_nodiv
      assign wrap = run;
    end else begin : g_div
      localparam int CW = $clog2(HALF_CYCLES);
      logic [CW-1:0] cnt_q, cnt_d;

      always_comb begin
        cnt_d = cnt_q;
        if (!run) begin
          cnt_d = '0;
        end else if (cnt_q == CW'(HALF_CYCLES - 1)) begin
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign wrap = run && (cnt_q == CW'(HALF_CYCLES - 1));
    end
  endgenerate

  always_comb begin
    mdc_d = mdc_q;
    if (!run)      mdc_d = 1'b0;
    else if (wrap) mdc_d = !mdc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mdc_q <= 1'b0;
    else        mdc_q <= mdc_d;
  end

  assign mdc     = mdc_q;
  assign rise_en = wrap && !mdc_q;
  assign fall_en = wrap && mdc_q;

  // R5: the clock line is low in every cycle that follows an idle cycle
  a_r5_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc);
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_bridge_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  mdio_cmd_t   cmd,
  input  logic        rise_en,
  input  logic        fall_en,
  input  logic        mdio_i,
  output logic        busy,
  output logic        fin,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic [15:0] rx_data
);
  logic                  busy_q, busy_d;
  logic                  rd_q, rd_d;
  logic [FRAME_BITS-1:0] sreg_q, sreg_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic [15:0]           rx_q, rx_d;
  logic                  last_bit;

  assign last_bit = (idx_q == IDX_W'(FRAME_BITS - 1));
  assign fin      = fall_en && last_bit;

  always_comb begin
    busy_d = busy_q;
    rd_d   = rd_q;
    sreg_d = sreg_q;
    idx_d  = idx_q;
    rx_d   = rx_q;
    if (start) begin
      busy_d = 1'b1;
      rd_d   = cmd.rd;
      sreg_d = build_frame(cmd);
      idx_d  = '0;
    end else if (fall_en) begin
      if (last_bit) begin
        busy_d = 1'b0;
      end else begin
        idx_d  = idx_q + 1'b1;
        sreg_d = {sreg_q[FRAME_BITS-2:0], 1'b0};
      end
    end
    if (rise_en && rd_q && (idx_q >= IDX_W'(RD_CAPTURE))) begin
      rx_d = {rx_q[14:0], mdio_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      sreg_q <= '0;
      idx_q  <= '0;
      rx_q   <= '0;
    end else begin
      busy_q <= busy_d;
      rd_q   <= rd_d;
      sreg_q <= sreg_d;
      idx_q  <= idx_d;
      rx_q   <= rx_d;
    end
  end

  assign busy    = busy_q;
  assign mdio_o  = sreg_q[FRAME_BITS-1];
  assign mdio_oe = busy_q && !(rd_q && (idx_q >= IDX_W'(RD_RELEASE)));
  assign rx_data = rx_q;

  // R5: within a frame the data line moves only after a falling clock edge
  a_r5_mdio_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && !$past(fall_en)) |-> $stable(mdio_o));

  // R7: a start request never arrives while a frame is running
  a_r7_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !start);
endmodule

// File: rtl/mdio_cmd_bridge.sv
module mdio_cmd_bridge
  import mdio_bridge_pkg::*;
#(
  parameter int HALF_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic        eng_busy, eng_fin, rise_en, fall_en;
  logic [15:0] rx_data;
  logic        accept;
  mdio_cmd_t   cmd;

  logic [31:0] cmd_q, cmd_d;
  logic        wr_done_q, wr_done_d;
  logic        rd_rdy_q, rd_rdy_d;
  logic [15:0] rd_data_q, rd_data_d;

  assign cmd    = decode_cmd(reg_wdata);
  assign accept = reg_wr && !reg_addr && !eng_busy && (reg_wdata[13] || reg_wdata[14]);

  mdio_tick_gen #(.HALF_CYCLES(HALF_CYCLES)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (eng_busy),
    .mdc     (mdc),
    .rise_en (rise_en),
    .fall_en (fall_en)
  );

  mdio_frame_engine u_engine (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .cmd     (cmd),
    .rise_en (rise_en),
    .fall_en (fall_en),
    .mdio_i  (mdio_i),
    .busy    (eng_busy),
    .fin     (eng_fin),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .rx_data (rx_data)
  );

  always_comb begin
    cmd_d     = cmd_q;
    wr_done_d = wr_done_q;
    rd_rdy_d  = rd_rdy_q;
    rd_data_d = rd_data_q;
    if (accept) begin
      cmd_d = reg_wdata;
      if (reg_wdata[14]) begin
        rd_rdy_d  = 1'b0;
        rd_data_d = 16'hFFFF;
      end else begin
        wr_done_d = 1'b0;
      end
    end else if (eng_fin) begin
      if (cmd_q[14]) begin
        rd_rdy_d  = 1'b1;
        rd_data_d = rx_data;
      end else begin
        wr_done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      wr_done_q <= 1'b0;
      rd_rdy_q  <= 1'b0;
      rd_data_q <= 16'hFFFF;
    end else begin
      cmd_q     <= cmd_d;
      wr_done_q <= wr_done_d;
      rd_rdy_q  <= rd_rdy_d;
      rd_data_q <= rd_data_d;
    end
  end

  assign reg_rdata = reg_addr ? {rd_data_q, 14'b0, rd_rdy_q, wr_done_q} : cmd_q;

  // R6: accepting a write drops the write flag
  a_r6_wr_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !reg_wdata[14]) |=> !wr_done_q);

  // R6: accepting a read drops the read flag and presets the data
  a_r6_rd_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && reg_wdata[14]) |=> (!rd_rdy_q && rd_data_q == 16'hFFFF));

  // R6: the end of a frame raises the flag of its operation
  a_r6_flag_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
    eng_fin |=> (cmd_q[14] ? rd_rdy_q : wr_done_q));

  // R7: command writes during a frame leave the stored command alone
  a_r7_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && reg_wr && !reg_addr) |=> $stable(cmd_q));
endmodule

// File: tb/mdio_cmd_bridge_tb.sv
module mdio_cmd_bridge_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;
  localparam int FRAME_CYC = 128 * HALF;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic        reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // behavioural reference state
  bit          m_busy;
  int          m_t;
  bit          m_rd;
  logic [63:0] m_frame;
  bit          m_wr_done, m_rd_rdy;
  logic [15:0] m_rdd;
  logic [31:0] m_cmd;
  logic [15:0] phy_val;
  int          m_starts;

  mdio_cmd_bridge #(.HALF_CYCLES(HALF)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .mdio_i    (mdio_i)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    if (!rst_n) begin
      m_busy = 0; m_t = 0; m_rd = 0; m_frame = '0;
      m_wr_done = 0; m_rd_rdy = 0; m_rdd = 16'hFFFF; m_cmd = '0;
    end else if (m_busy) begin
      m_t++;
      if (m_t == FRAME_CYC) begin
        m_busy = 0;
        if (m_rd) begin m_rd_rdy = 1; m_rdd = phy_val; end
        else m_wr_done = 1;
      end
    end else if (reg_wr && !reg_addr && (reg_wdata[13] || reg_wdata[14])) begin
      m_busy = 1; m_t = 0; m_starts++;
      m_cmd = reg_wdata;
      m_rd = reg_wdata[14];
      m_frame = {32'hFFFF_FFFF, 2'b01, (m_rd ? 2'b10 : 2'b01), reg_wdata[4:0],
                 reg_wdata[12:8], 2'b10, (m_rd ? 16'h0000 : reg_wdata[31:16])};
      if (m_rd) begin m_rd_rdy = 0; m_rdd = 16'hFFFF; end
      else m_wr_done = 0;
    end
  endtask

  task automatic compare_all();
    int  b;
    bit  e_mdc, e_oe;
    b = m_t / (2 * HALF);
    e_mdc = m_busy && ((m_t % (2 * HALF)) >= HALF);
    e_oe  = m_busy && !(m_rd && b >= 46);
    check("R5 mdc", {31'b0, mdc}, {31'b0, e_mdc});
    check(m_rd ? "R4 mdio_oe" : "R3 mdio_oe", {31'b0, mdio_oe}, {31'b0, e_oe});
    if (e_oe) check(m_rd ? "R4 mdio_o" : "R3 mdio_o", {31'b0, mdio_o}, {31'b0, m_frame[63-b]});
    if (reg_addr) check("R6 status", reg_rdata, {m_rdd, 14'b0, m_rd_rdy, m_wr_done});
    else          check("R8 cmd readback", reg_rdata, m_cmd);
  endtask

  task automatic tick();
    int b;
    @(negedge clk);
    model_step();
    compare_all();
    b = m_t / (2 * HALF);
    if (m_busy && m_rd && b >= 48) mdio_i = phy_val[63-b];
    else mdio_i = 1'b1;
  endtask

  task automatic issue(input logic [31:0] w);
    reg_addr = 1'b0; reg_wdata = w; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4 * FRAME_CYC && m_busy; i++) tick();
  endtask

  task automatic peek_status(input string req, input logic [31:0] exp);
    reg_addr = 1'b1;
    #1;
    check(req, reg_rdata, exp);
    tick();
  endtask

  initial begin
    int s0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 1'b1; reg_wdata = '0;
    mdio_i = 1'b1; phy_val = 16'h0000; m_starts = 0;
    repeat (3) tick();
    // R1 reset state
    check("R1 status", reg_rdata, 32'hFFFF_0000);
    check("R1 mdc", {31'b0, mdc}, 32'd0);
    check("R1 oe", {31'b0, mdio_oe}, 32'd0);
    rst_n = 1'b1;
    tick();

    // R3 write frame, R6 flag clear then set
    issue(32'hA5C3_2305);
    peek_status("R6 write flag low", 32'hFFFF_0000);
    for (int i = 0; i < 40; i++) tick();
    // R7 a command during the frame is ignored
    issue(32'h0000_4011);
    reg_addr = 1'b0; #1;
    check("R7 busy cmd ignored", reg_rdata, 32'hA5C3_2305);
    wait_idle();
    peek_status("R6 write done", 32'hFFFF_0001);

    // R4 read frame and capture
    phy_val = 16'h1234;
    issue(32'h0000_511F);
    peek_status("R6 read flag low", 32'hFFFF_0001);
    wait_idle();
    peek_status("R4 read data", 32'h1234_0003);

    // R2 both request bits: read wins
    phy_val = 16'hCAFE;
    issue(32'hBEEF_6207);
    wait_idle();
    peek_status("R2 both bits read", 32'hCAFE_0003);
    reg_addr = 1'b0; #1;
    check("R8 readback", reg_rdata, 32'hBEEF_6207);

    // R2 neither bit: nothing starts
    s0 = m_starts;
    issue(32'h1111_0A0A);
    for (int i = 0; i < 8; i++) tick();
    check("R2 no-op oe", {31'b0, mdio_oe}, 32'd0);
    check("R2 no-op mdc", {31'b0, mdc}, 32'd0);
    check("R2 no-op readback", reg_rdata, 32'hBEEF_6207);

    // R7 write to status address ignored
    reg_addr = 1'b1; reg_wdata = 32'h0000_6000; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
    for (int i = 0; i < 8; i++) tick();
    check("R7 status write ignored oe", {31'b0, mdio_oe}, 32'd0);
    peek_status("R7 status write ignored", 32'hCAFE_0003);
    check("R2 no starts", m_starts, s0);

    // R7 command held across the end of a frame: accepted only after it
    s0 = m_starts;
    reg_addr = 1'b0; reg_wdata = 32'h0F0F_2001; reg_wr = 1'b1;
    for (int i = 0; i < 4 * FRAME_CYC && m_starts < s0 + 2; i++) tick();
    reg_wr = 1'b0;
    check("R7 restart after end", m_starts, s0 + 2);
    wait_idle();
    peek_status("R6 held write done", 32'hCAFE_0003);
    for (int i = 0; i < 4; i++) tick();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule